// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable device-side model of a 1-kbit serial EEPROM. A host drives a chip-select line, a serial clock and a serial data input; the block decodes a framed command and answers on a serial data output that has its own output-enable, so the pad can be tri-stated. All three serial pins are brought into the system clock domain through synchronizer flops. Rising edges of the serial clock are found by edge detection, and the block samples on them.

The storage is a register array of 1024 bits. A static organisation input picks how it is seen: 64 words of 16 bits, or 128 bytes of 8 bits. The supported commands are read, single-location write and erase, whole-array write and erase, and enable and disable of programming. A program operation occupies a self-timed cycle that is counted in system clocks. While it runs, the host can poll a ready/busy flag on the data output by dropping and raising chip select.

Top module: `serial_eeprom_dev`

## Requirements
- R1: With `wide_org_i` high the array is 64 words of 16 bits with a 6-bit address. With it low the array is 128 bytes with a 7-bit address. Byte address bit 0 picks the lane: 0 is bits 7:0 and 1 is bits 15:8 of word address[6:1].
- R2: A command opens only while chip select is high, with a 1 on the data input. Zeros before that 1 are ignored. A 2-bit opcode follows, MSB first, and then the address, MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 group.
- R3: A read drives a 0 on the data output after the last address bit. The 16 or 8 data bits follow, MSB first, one per serial clock rise. The next rise after the last data bit tri-states the output. A read works whatever the state of the programming latch.
- R4: The programming latch is clear after reset. Group code 11 (the top two address bits) sets it and group code 00 clears it. Write, erase and both whole-array commands have no effect while it is clear.
- R5: Erase (opcode 11) sets the addressed word or byte to all ones. Group code 10 sets the whole array to all ones.
- R6: Write (opcode 01) stores the data bits that follow the address, MSB first, without a prior erase. Group code 01 stores the same data into every word, or into every byte in the 8-bit organisation.
- R7: A program operation starts on the clock that decodes its last bit and keeps the block busy for exactly PROG_CYCLES system clocks.
- R8: A chip-select rise while busy enables the output and shows 0 until the cycle ends and 1 afterwards. A chip-select rise after the cycle has ended shows no status.
- R9: The output enable is low whenever chip select is low, and at all times outside read data and status.
- R10: A command sent while a program cycle runs is ignored.
- R11: Chip select falling before a command is complete discards it with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_org_i | input | 1 | Organisation: 1 selects 64x16, 0 selects 128x8 (static) |
| csel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output (read data or ready/busy) |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
The bench uses a table of patterns. These include full-word writes at the lowest and highest word addresses, byte writes to both lanes of one word read back as a full word, and a byte erase next to a cleared lane. Together they separate lane selection, bit order and the two address widths. Directed sequences cover the rest: leading zeros before the start bit, whole-array fills in both organisations, a command issued during a program cycle and a frame cut short by chip select. They also cover programming attempts with the latch clear, both after reset and after a disable command. Polling during the program cycle measures its length and checks that status disappears once the cycle is over.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_STATUS,
    ST_HOLD
  } eep_state_e;

  // two-bit command codes
  localparam logic [1:0] OP_GRP   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // group sub-codes carried in the top two address bits
  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [STAGES:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-1:0], pin_i};
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  parameter int LANES = 2,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic             all_i,
  input  logic [LANES-1:0] lane_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  localparam int LW = WIDTH / LANES;

  logic [WORDS*WIDTH-1:0] flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = we_i && (all_i || (waddr_i == AW'(w)));
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic          lane_en;
      logic [LW-1:0] lane_q;
      assign lane_en = hit && lane_i[l];
      always_ff @(posedge clk) begin
        if (lane_en) begin
          lane_q <= wdata_i[l*LW +: LW];
        end
      end
      assign flat[w*WIDTH + l*LW +: LW] = lane_q;
    end
  end

  assign rdata_o = flat[raddr_i*WIDTH +: WIDTH];

endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  localparam int WAW  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_i,
  input  logic             cs_i,
  input  logic             cs_rise_i,
  input  logic             sck_rise_i,
  input  logic             sdi_i,
  input  logic             busy_i,
  input  logic [WIDTH-1:0] rd_word_i,
  output logic [WAW-1:0]   rd_addr_o,
  output logic             prog_go_o,
  output logic             wr_all_o,
  output logic [1:0]       wr_lanes_o,
  output logic [WAW-1:0]   wr_addr_o,
  output logic [WIDTH-1:0] wr_data_o,
  output logic             wen_o,
  output logic             sdo_o,
  output logic             sdo_en_o
);

  localparam int BAW  = WAW + 1;
  localparam int HALF = WIDTH / 2;
  localparam int CW   = $clog2(WIDTH + 2);

  eep_state_e       state_q, state_d;
  logic [1:0]       opc_q, opc_d;
  logic [BAW-1:0]   addr_q, addr_d, addr_n;
  logic [WIDTH-1:0] data_q, data_d, data_n;
  logic [WIDTH-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    addr_last, data_last;
  logic             dout_q, dout_d;
  logic             wen_q, wen_d;
  logic [1:0]       top2;

  function automatic logic [WAW-1:0] word_of(input logic wide, input logic [BAW-1:0] a);
    return wide ? a[WAW-1:0] : a[BAW-1:1];
  endfunction

  function automatic logic [1:0] lanes_of(input logic wide, input logic hi);
    return wide ? 2'b11 : (hi ? 2'b10 : 2'b01);
  endfunction

  assign addr_n    = {addr_q[BAW-2:0], sdi_i};
  assign data_n    = {data_q[WIDTH-2:0], sdi_i};
  assign addr_last = wide_i ? CW'(WAW - 1) : CW'(BAW - 1);
  assign data_last = wide_i ? CW'(WIDTH - 1) : CW'(HALF - 1);
  assign top2      = wide_i ? addr_n[WAW-1:WAW-2] : addr_n[BAW-1:BAW-2];
  assign rd_addr_o = word_of(wide_i, addr_n);

  always_comb begin
    state_d    = state_q;
    opc_d      = opc_q;
    addr_d     = addr_q;
    data_d     = data_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    dout_d     = dout_q;
    wen_d      = wen_q;
    prog_go_o  = 1'b0;
    wr_all_o   = 1'b0;
    wr_lanes_o = 2'b00;
    wr_addr_o  = '0;
    wr_data_o  = '0;

    if (!cs_i) begin
      state_d = ST_IDLE;
      dout_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cs_rise_i && busy_i) begin
            state_d = ST_STATUS;
          end else if (sck_rise_i && sdi_i && !busy_i) begin
            state_d = ST_OPC;
            opc_d   = 2'b00;
            cnt_d   = '0;
          end
        end

        ST_OPC: begin
          if (sck_rise_i) begin
            opc_d = {opc_q[0], sdi_i};
            if (cnt_q == CW'(1)) begin
              state_d = ST_ADDR;
              cnt_d   = '0;
              addr_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_ADDR: begin
          if (sck_rise_i) begin
            addr_d = addr_n;
            if (cnt_q == addr_last) begin
              cnt_d   = '0;
              data_d  = '0;
              state_d = ST_HOLD;
              unique case (opc_q)
                OP_READ: begin
                  state_d = ST_READ;
                  dout_d  = 1'b0;
                  if (wide_i) begin
                    sh_d = rd_word_i;
                  end else if (addr_n[0]) begin
                    sh_d = {rd_word_i[WIDTH-1:HALF], {HALF{1'b0}}};
                  end else begin
                    sh_d = {rd_word_i[HALF-1:0], {HALF{1'b0}}};
                  end
                end
                OP_WRITE: begin
                  state_d = ST_DATA;
                end
                OP_ERASE: begin
                  if (wen_q) begin
                    prog_go_o  = 1'b1;
                    wr_lanes_o = lanes_of(wide_i, addr_n[0]);
                    wr_addr_o  = word_of(wide_i, addr_n);
                    wr_data_o  = '1;
                  end
                end
                default: begin
                  unique case (top2)
                    SUB_UNLOCK: wen_d = 1'b1;
                    SUB_LOCK:   wen_d = 1'b0;
                    SUB_CLEAR: begin
                      if (wen_q) begin
                        prog_go_o  = 1'b1;
                        wr_all_o   = 1'b1;
                        wr_lanes_o = 2'b11;
                        wr_data_o  = '1;
                      end
                    end
                    default: state_d = ST_DATA;
                  endcase
                end
              endcase
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_DATA: begin
          if (sck_rise_i) begin
            data_d = data_n;
            if (cnt_q == data_last) begin
              state_d = ST_HOLD;
              cnt_d   = '0;
              if (wen_q) begin
                prog_go_o  = 1'b1;
                wr_all_o   = (opc_q == OP_GRP);
                wr_lanes_o = (opc_q == OP_GRP) ? 2'b11 : lanes_of(wide_i, addr_q[0]);
                wr_addr_o  = word_of(wide_i, addr_q);
                wr_data_o  = wide_i ? data_n : {2{data_n[HALF-1:0]}};
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_READ: begin
          if (sck_rise_i) begin
            if (cnt_q == data_last + 1'b1) begin
              state_d = ST_HOLD;
              dout_d  = 1'b0;
            end else begin
              dout_d = sh_q[WIDTH-1];
              sh_d   = {sh_q[WIDTH-2:0], 1'b0};
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end

        ST_STATUS: state_d = ST_STATUS;

        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      dout_q  <= 1'b0;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      dout_q  <= dout_d;
      wen_q   <= wen_d;
    end
  end

  assign wen_o    = wen_q;
  assign sdo_en_o = cs_i && ((state_q == ST_READ) || (state_q == ST_STATUS));
  assign sdo_o    = (state_q == ST_STATUS) ? ~busy_i : dout_q;

endmodule

// File: rtl/serial_eeprom_dev.sv
module serial_eeprom_dev #(
  parameter int WORDS       = 64,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_org_i,
  input  logic csel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);

  localparam int WAW = $clog2(WORDS);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [2:0]       pin_sync, pin_prev;
  logic             cs_s, cs_rise, sck_rise, sdi_s;
  logic             busy, prog_go, wr_all, wen_q;
  logic [1:0]       wr_lanes;
  logic [WAW-1:0]   wr_addr, rd_addr;
  logic [WIDTH-1:0] wr_data, rd_word;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  eep_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  ({csel_i, sclk_i, sdi_i}),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  assign cs_s     = pin_sync[2];
  assign cs_rise  = pin_sync[2] & ~pin_prev[2];
  assign sck_rise = pin_sync[1] & ~pin_prev[1];
  assign sdi_s    = pin_sync[0];

  eep_cmd_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wide_i     (wide_org_i),
    .cs_i       (cs_s),
    .cs_rise_i  (cs_rise),
    .sck_rise_i (sck_rise),
    .sdi_i      (sdi_s),
    .busy_i     (busy),
    .rd_word_i  (rd_word),
    .rd_addr_o  (rd_addr),
    .prog_go_o  (prog_go),
    .wr_all_o   (wr_all),
    .wr_lanes_o (wr_lanes),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wen_o      (wen_q),
    .sdo_o      (sdo_o),
    .sdo_en_o   (sdo_oe_o)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (prog_go),
    .busy_o  (busy)
  );

  eep_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .LANES(2)) u_array (
    .clk     (clk),
    .we_i    (prog_go),
    .all_i   (wr_all),
    .lane_i  (wr_lanes),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic busy,
  input logic prog_go,
  input logic wen_q,
  input logic sdo_o,
  input logic sdo_oe_o
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else begin
      run_q <= busy ? run_q + 1 : 0;
    end
  end

  // R7: busy stretch measured by a counter
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == PROG_CYCLES));

  assert_prog_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> wen_q);

  assert_no_start_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> !busy);

  assert_oe_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> cs_s);

  assert_busy_shows_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && busy) |-> !sdo_o);

  assert_read_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe_o) && !$past(busy)) |-> !sdo_o);

endmodule

bind serial_eeprom_dev eep_checker #(.PROG_CYCLES(PROG_CYCLES)) i_eep_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .busy     (busy),
  .prog_go  (prog_go),
  .wen_q    (wen_q),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/test_serial_eeprom_dev.sv
module test_serial_eeprom_dev;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int PROG       = 600;

  typedef struct packed {
    logic        org;
    logic [1:0]  kind;  // 0 write, 1 erase, 2 read only
    logic [6:0]  addr;
    logic [15:0] data;
    logic [15:0] expv;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 2'd0, 7'd5,  16'hA5C3, 16'hA5C3},
    '{1'b1, 2'd0, 7'd63, 16'h1234, 16'h1234},
    '{1'b0, 2'd0, 7'd10, 16'h007E, 16'h007E},
    '{1'b0, 2'd0, 7'd11, 16'h0081, 16'h0081},
    '{1'b1, 2'd2, 7'd5,  16'h0000, 16'h817E},
    '{1'b1, 2'd0, 7'd0,  16'h0000, 16'h0000},
    '{1'b0, 2'd1, 7'd1,  16'h0000, 16'h00FF},
    '{1'b1, 2'd2, 7'd0,  16'h0000, 16'hFF00},
    '{1'b1, 2'd1, 7'd63, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n, org, cs, sck, sdi;
  logic sdo, oe;
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_dev #(.PROG_CYCLES(PROG)) i_serial_eeprom_dev (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_org_i (org),
    .csel_i     (cs),
    .sclk_i     (sck),
    .sdi_i      (sdi),
    .sdo_o      (sdo),
    .sdo_oe_o   (oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdi = b; sck = 1'b0; idle(HALF);
    sck = 1'b1; idle(HALF);
  endtask

  task automatic cs_on();
    sck = 1'b0; cs = 1'b1; idle(4);
  endtask

  task automatic cs_off();
    sck = 1'b0; cs = 1'b0; sdi = 1'b0; idle(6);
  endtask

  task automatic shift(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  function automatic int aw();
    return org ? 6 : 7;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [6:0] a,
                       input logic [15:0] d, input bit with_d);
    cs_on();
    pulse(1'b1);
    shift({14'b0, op}, 2);
    shift({9'b0, a}, aw());
    if (with_d) shift(d, dw());
    cs_off();
  endtask

  task automatic grp(input logic [1:0] sub, input logic [15:0] d, input bit with_d);
    issue(2'b00, org ? {1'b0, sub, 4'b0} : {sub, 5'b0}, d, with_d);
  endtask

  task automatic rd(input logic [6:0] a, input int lead, output logic [15:0] val,
                    output logic dummy_ok, output logic tail_oe);
    cs_on();
    repeat (lead) pulse(1'b0);
    pulse(1'b1);
    shift(16'd2, 2);
    shift({9'b0, a}, aw());
    dummy_ok = (oe === 1'b1) && (sdo === 1'b0);
    val = '0;
    for (int i = 0; i < dw(); i++) begin
      pulse(1'b0);
      val = {val[14:0], sdo};
    end
    pulse(1'b0);
    tail_oe = oe;
    cs_off();
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] expv);
    logic [15:0] v;
    logic        dk, t;
    rd(a, 0, v, dk, t);
    check({req, " dummy"}, {15'b0, dk}, 16'd1);
    check(req, v, expv);
  endtask

  task automatic settle();
    idle(PROG + 30);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        dk, t;
    int          n;
    rst_n = 1'b0; org = 1'b1; cs = 1'b0; sck = 1'b0; sdi = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    check("R9 reset oe", {15'b0, oe}, 16'd0);

    // R4: latch clear after reset, a write must not start a cycle
    issue(2'b01, 7'd3, 16'hBEEF, 1'b1);
    cs_on();
    check("R4 no status without latch", {15'b0, oe}, 16'd0);
    cs_off();
    grp(2'b11, 16'h0, 1'b0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      org = VEC[i].org;
      if (VEC[i].kind == 2'd0) begin
        issue(2'b01, VEC[i].addr, VEC[i].data, 1'b1);
        settle();
        rd_chk("R6 R1 table write", VEC[i].addr, VEC[i].expv);
      end else if (VEC[i].kind == 2'd1) begin
        issue(2'b11, VEC[i].addr, 16'h0, 1'b0);
        settle();
        rd_chk("R5 R1 table erase", VEC[i].addr, VEC[i].expv);
      end else begin
        rd_chk("R1 table read", VEC[i].addr, VEC[i].expv);
      end
    end
    org = 1'b1;

    // R2 leading zeros, R3 tail tri-state
    issue(2'b01, 7'd63, 16'h1234, 1'b1);
    settle();
    rd(7'd63, 3, v, dk, t);
    check("R2 leading zeros", v, 16'h1234);
    check("R3 tail oe", {15'b0, t}, 16'd0);

    // R8 status and R7 length
    issue(2'b01, 7'd20, 16'hCAFE, 1'b1);
    cs_on();
    check("R8 busy oe", {15'b0, oe}, 16'd1);
    check("R8 busy value", {15'b0, sdo}, 16'd0);
    n = 0;
    while (sdo !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (n < PROG - 20 || n > PROG - 8) begin
      errors++;
      $display("FAIL R7 cycle length: actual=%0d expected=%0d..%0d", n, PROG - 20, PROG - 8);
    end
    check("R8 ready value", {14'b0, oe, sdo}, 16'd3);
    cs_off();
    cs_on();
    check("R8 no status after end", {15'b0, oe}, 16'd0);
    cs_off();
    rd_chk("R6 write", 7'd20, 16'hCAFE);

    // R10 command during busy
    issue(2'b01, 7'd21, 16'h0F0F, 1'b1);
    issue(2'b01, 7'd20, 16'h0000, 1'b1);
    settle();
    rd_chk("R10 ignored write", 7'd20, 16'hCAFE);
    rd_chk("R10 first write", 7'd21, 16'h0F0F);

    // R11 aborted frame
    cs_on();
    pulse(1'b1);
    shift(16'd1, 2);
    shift(16'd20, 6);
    shift(16'h00FF, 8);
    cs_off();
    cs_on();
    check("R11 no cycle", {15'b0, oe}, 16'd0);
    cs_off();
    rd_chk("R11 unchanged", 7'd20, 16'hCAFE);

    // R5 whole-array erase
    grp(2'b10, 16'h0, 1'b0);
    settle();
    rd_chk("R5 clear low", 7'd0, 16'hFFFF);
    rd_chk("R5 clear high", 7'd63, 16'hFFFF);

    // R6 whole-array fill in byte organisation
    org = 1'b0;
    grp(2'b01, 16'h003C, 1'b1);
    settle();
    org = 1'b1;
    rd_chk("R6 fill", 7'd7, 16'h3C3C);
    rd_chk("R6 fill", 7'd40, 16'h3C3C);

    // R4 disable, R3 read independent of latch
    grp(2'b00, 16'h0, 1'b0);
    issue(2'b01, 7'd7, 16'h0000, 1'b1);
    cs_on();
    check("R4 locked no cycle", {15'b0, oe}, 16'd0);
    cs_off();
    rd_chk("R4 R3 locked read", 7'd7, 16'h3C3C);

    // R4 reset clears latch
    grp(2'b11, 16'h0, 1'b0);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    issue(2'b11, 7'd7, 16'h0, 1'b0);
    settle();
    rd_chk("R4 latch after reset", 7'd7, 16'h3C3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule